// File: doc/BRIEF.md
# Counter Read Permission Gate

This block decides, in a single combinational pass, whether a read of one of the user-level counter CSRs may go ahead. It sits beside the CSR read path of a processor core. Each cycle it takes the CSR address, the current privilege level, a virtualization flag, the base integer width and four 32-bit masks: the machine, hypervisor and supervisor counter-enable registers, and a mask of the hardware performance counters that actually exist. From these it produces the counter index, a flag saying whether the address is a counter CSR at all, and a two-bit verdict. The verdict is one of three outcomes: allowed, illegal-instruction exception, or virtual-instruction exception.

The fixed counters (cycle, time, retired instructions) and the hardware performance counters are handled as one bit-indexed family. A single one-hot mask, derived from the counter index, selects the relevant bit out of every enable register. The checks are layered in a fixed priority. The first check that fails sets the outcome, and later checks are not consulted.

Top module: `ctrAccessGate`

## Requirements
- R1: An address in 0xC00..0xC1F is a counter (isCounter=1), and ctrIndex equals the address minus 0xC00.
- R2: An address in 0xC80..0xC9F is a counter with ctrIndex equal to the address minus 0xC80 only when isRv32=1. With isRv32=0 it gives isCounter=0 and verdict 00.
- R3: Any address that is not a counter gives isCounter=0, ctrIndex=0 and verdict 00, whatever the other inputs are.
- R4: The verdict encoding is 00 for allowed, 01 for illegal instruction and 10 for virtual instruction. The code 11 never appears.
- R5: For counter index 3 or above, the verdict is 01 when hpmCount is 0 or when bit ctrIndex of hpmAvail is 0. This check comes before every other check and applies at every privilege level. Indices 0, 1 and 2 skip it.
- R6: Privilege is encoded U=0, S=1, M=3. In M (3), any counter that passes R5 is allowed, and virtOn, mEnable, hEnable and sEnable have no effect.
- R7: Below M (privLvl other than 3), a clear mEnable[ctrIndex] gives 01. This holds even when virtOn=1.
- R8: When virtOn=1 and privLvl is below M, a set mEnable bit together with a clear hEnable[ctrIndex] gives 10.
- R9: In U (0) with sModeImpl=1, a clear sEnable[ctrIndex] gives 01 when virtOn=0 and 10 when virtOn=1. With sModeImpl=0, sEnable has no effect.
- R10: sEnable has no effect in S (1). hEnable has no effect when virtOn=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| csrAddr | input | 12 | CSR address being read |
| privLvl | input | 2 | Current privilege level (U=0, S=1, M=3) |
| virtOn | input | 1 | Virtualization active (VS or VU when below M) |
| isRv32 | input | 1 | 1 when the base integer width is 32 bits |
| sModeImpl | input | 1 | 1 when supervisor mode is implemented |
| hpmCount | input | 6 | Number of configured performance counters; 0 means none |
| hpmAvail | input | 32 | Bit N set when counter N is implemented |
| mEnable | input | 32 | Machine-level counter enables |
| hEnable | input | 32 | Hypervisor-level counter enables |
| sEnable | input | 32 | Supervisor-level counter enables |
| isCounter | output | 1 | Address is a counter CSR in the current width |
| ctrIndex | output | 5 | Derived counter index |
| verdict | output | 2 | 00 allowed, 01 illegal instruction, 10 virtual instruction |

## Verification
The embedded assertions are evaluated whenever the inputs change. They check that the code 11 never appears, that the selection mask is one-hot exactly when the address hits, that a missing performance counter always yields an illegal verdict, that machine mode allows every implemented counter, that a virtual verdict only occurs while virtualized below machine mode, and that a non-counter address stays quiet. The precise ordering among the machine, hypervisor and supervisor checks can only be shown by the bench scenarios. The same goes for the high-half window's dependence on the integer width and for the exact index arithmetic, because these need stimulus with one enable cleared at a time and known expected results.

// File: rtl/ctrGatePkg.sv
package ctrGatePkg;

  localparam int ADDR_W = 12;

  localparam logic [1:0] PRIV_U = 2'd0;
  localparam logic [1:0] PRIV_S = 2'd1;
  localparam logic [1:0] PRIV_M = 2'd3;

  typedef enum logic [1:0] {
    VERDICT_ALLOW   = 2'b00,
    VERDICT_ILLEGAL = 2'b01,
    VERDICT_VIRTUAL = 2'b10
  } verdict_e;

  // Strobes handed from the decode datapath to the permission control.
  typedef struct packed {
    logic hit;         // address is a counter in the current width
    logic fixedCtr;    // index below the first performance counter
    logic hpmMissing;  // performance counter not configured or absent
    logic mOk;         // selected machine enable bit
    logic hOk;         // selected hypervisor enable bit
    logic sOk;         // selected supervisor enable bit
  } ctrSel_t;

endpackage

// File: rtl/ctrIndexDecode.sv
module ctrIndexDecode
  import ctrGatePkg::*;
#(
  parameter int NUM_CTR = 32,
  parameter int FIXED_CNT = 3,
  parameter logic [ADDR_W-1:0] LOW_BASE = 12'hC00,
  parameter logic [ADDR_W-1:0] HIGH_BASE = 12'hC80,
  localparam int IDX_W = $clog2(NUM_CTR),
  localparam int CNT_W = $clog2(NUM_CTR + 1)
) (
  input  logic [ADDR_W-1:0]  csrAddr,
  input  logic               isRv32,
  input  logic [CNT_W-1:0]   hpmCount,
  input  logic [NUM_CTR-1:0] hpmAvail,
  input  logic [NUM_CTR-1:0] mEnable,
  input  logic [NUM_CTR-1:0] hEnable,
  input  logic [NUM_CTR-1:0] sEnable,
  output logic [IDX_W-1:0]   ctrIndex,
  output ctrSel_t            sel
);

  localparam logic [ADDR_W-1:0] RANGE_SZ = ADDR_W'(NUM_CTR);
  localparam logic [IDX_W-1:0]  FIXED_LIM = IDX_W'(FIXED_CNT);

  logic [ADDR_W-1:0]  lowOff;
  logic [ADDR_W-1:0]  highOff;
  logic               lowHit;
  logic               highHit;
  logic               anyHit;
  logic [NUM_CTR-1:0] oneHot;

  assign lowOff  = csrAddr - LOW_BASE;
  assign highOff = csrAddr - HIGH_BASE;
  assign lowHit  = (lowOff < RANGE_SZ);
  assign highHit = isRv32 && (highOff < RANGE_SZ);
  assign anyHit  = lowHit || highHit;

  always_comb begin
    if (lowHit)       ctrIndex = IDX_W'(lowOff);
    else if (highHit) ctrIndex = IDX_W'(highOff);
    else              ctrIndex = '0;
  end

  // One select line per counter; the same mask picks a bit out of every register.
  for (genvar g = 0; g < NUM_CTR; g++) begin : gSel
    assign oneHot[g] = anyHit && (ctrIndex == IDX_W'(g));
  end

  always_comb begin
    sel.hit        = anyHit;
    sel.fixedCtr   = (ctrIndex < FIXED_LIM);
    sel.hpmMissing = anyHit && !sel.fixedCtr &&
                     ((hpmCount == '0) || !(|(hpmAvail & oneHot)));
    sel.mOk        = |(mEnable & oneHot);
    sel.hOk        = |(hEnable & oneHot);
    sel.sOk        = |(sEnable & oneHot);
  end

  always_comb begin
    assert_onehot_mask_R1: assert ($onehot0(oneHot) && ((|oneHot) == anyHit))
      else $error("select mask not one-hot with hit");
    assert_wide_high_quiet_R2: assert (isRv32 || lowHit || !(highOff < RANGE_SZ) || !anyHit)
      else $error("high half decoded in 64-bit mode");
  end

endmodule

// File: rtl/ctrPermCtrl.sv
module ctrPermCtrl
  import ctrGatePkg::*;
(
  input  ctrSel_t    sel,
  input  logic [1:0] privLvl,
  input  logic       virtOn,
  input  logic       sModeImpl,
  output verdict_e   verdict
);

  logic belowM;
  logic virtAct;
  logic userLvl;

  assign belowM  = (privLvl != PRIV_M);
  assign virtAct = virtOn && belowM;
  assign userLvl = (privLvl == PRIV_U);

  // First failing check decides; order is part of the behaviour.
  always_comb begin
    verdict = VERDICT_ALLOW;
    if (!sel.hit) begin
      verdict = VERDICT_ALLOW;
    end else if (sel.hpmMissing) begin
      verdict = VERDICT_ILLEGAL;
    end else if (!belowM) begin
      verdict = VERDICT_ALLOW;
    end else if (!sel.mOk) begin
      verdict = VERDICT_ILLEGAL;
    end else if (virtAct && !sel.hOk) begin
      verdict = VERDICT_VIRTUAL;
    end else if (userLvl && sModeImpl && !sel.sOk) begin
      verdict = virtAct ? VERDICT_VIRTUAL : VERDICT_ILLEGAL;
    end
  end

  always_comb begin
    assert_no_reserved_code_R4: assert (verdict != 2'b11)
      else $error("reserved verdict code");
    assert_missing_hpm_illegal_R5: assert (!sel.hpmMissing || verdict == VERDICT_ILLEGAL)
      else $error("absent counter not illegal");
    assert_machine_allows_R6: assert (!(sel.hit && !sel.hpmMissing && privLvl == PRIV_M)
                                      || verdict == VERDICT_ALLOW)
      else $error("machine mode read refused");
    assert_virtual_needs_virt_R8: assert (verdict != VERDICT_VIRTUAL || (virtOn && belowM))
      else $error("virtual verdict outside virtualization");
  end

endmodule

// File: rtl/ctrAccessGate.sv
module ctrAccessGate
  import ctrGatePkg::*;
#(
  parameter int NUM_CTR = 32,
  localparam int IDX_W = $clog2(NUM_CTR),
  localparam int CNT_W = $clog2(NUM_CTR + 1)
) (
  input  logic [11:0]        csrAddr,
  input  logic [1:0]         privLvl,
  input  logic               virtOn,
  input  logic               isRv32,
  input  logic               sModeImpl,
  input  logic [CNT_W-1:0]   hpmCount,
  input  logic [NUM_CTR-1:0] hpmAvail,
  input  logic [NUM_CTR-1:0] mEnable,
  input  logic [NUM_CTR-1:0] hEnable,
  input  logic [NUM_CTR-1:0] sEnable,
  output logic               isCounter,
  output logic [IDX_W-1:0]   ctrIndex,
  output logic [1:0]         verdict
);

  ctrSel_t  selBits;
  verdict_e verdictE;

  ctrIndexDecode #(
    .NUM_CTR (NUM_CTR)
  ) u_decode (
    .csrAddr  (csrAddr),
    .isRv32   (isRv32),
    .hpmCount (hpmCount),
    .hpmAvail (hpmAvail),
    .mEnable  (mEnable),
    .hEnable  (hEnable),
    .sEnable  (sEnable),
    .ctrIndex (ctrIndex),
    .sel      (selBits)
  );

  ctrPermCtrl u_ctrl (
    .sel       (selBits),
    .privLvl   (privLvl),
    .virtOn    (virtOn),
    .sModeImpl (sModeImpl),
    .verdict   (verdictE)
  );

  assign isCounter = selBits.hit;
  assign verdict   = verdictE;

  always_comb begin
    assert_notctr_quiet_R3: assert (isCounter || (verdict == 2'b00 && ctrIndex == '0))
      else $error("non-counter address produced a decision");
  end

endmodule

// File: tb/ctrAccessGate_tb.sv
module ctrAccessGate_tb;

  localparam logic [31:0] ALL = 32'hFFFF_FFFF;

  typedef struct packed {
    logic [11:0] addr;
    logic [1:0]  priv;
    logic        virt;
    logic        rv32;
    logic        sImpl;
    logic [5:0]  cnt;
    logic [31:0] avail;
    logic [31:0] m;
    logic [31:0] h;
    logic [31:0] s;
    logic        expCtr;
    logic [4:0]  expIdx;
    logic [1:0]  expV;
    logic [3:0]  req;
  } vec_t;

  localparam int NV = 22;
  localparam vec_t VECS [NV] = '{
    '{12'hC00, 2'd0, 1'b0, 1'b0, 1'b1, 6'd29, ALL, ALL, ALL, ALL, 1'b1, 5'd0,  2'b00, 4'd1},  // R1
    '{12'hC1F, 2'd1, 1'b0, 1'b0, 1'b1, 6'd29, ALL, ALL, ALL, ALL, 1'b1, 5'd31, 2'b00, 4'd1},  // R1
    '{12'hC83, 2'd1, 1'b0, 1'b1, 1'b1, 6'd29, ALL, ALL, ALL, ALL, 1'b1, 5'd3,  2'b00, 4'd2},  // R2
    '{12'hC83, 2'd1, 1'b0, 1'b0, 1'b1, 6'd29, ALL, ALL, ALL, ALL, 1'b0, 5'd0,  2'b00, 4'd2},  // R2
    '{12'hC20, 2'd3, 1'b0, 1'b1, 1'b1, 6'd29, ALL, ALL, ALL, ALL, 1'b0, 5'd0,  2'b00, 4'd3},  // R3
    '{12'hB00, 2'd0, 1'b1, 1'b1, 1'b1, 6'd0,  ALL, 32'h0, 32'h0, 32'h0, 1'b0, 5'd0, 2'b00, 4'd3}, // R3
    '{12'hC05, 2'd3, 1'b0, 1'b0, 1'b1, 6'd0,  ALL, ALL, ALL, ALL, 1'b1, 5'd5,  2'b01, 4'd5},  // R5
    '{12'hC05, 2'd3, 1'b0, 1'b0, 1'b1, 6'd29, 32'hFFFF_FFDF, ALL, ALL, ALL, 1'b1, 5'd5, 2'b01, 4'd5}, // R5
    '{12'hC02, 2'd3, 1'b0, 1'b0, 1'b1, 6'd0,  32'h0, ALL, ALL, ALL, 1'b1, 5'd2, 2'b00, 4'd5}, // R5
    '{12'hC82, 2'd0, 1'b0, 1'b1, 1'b0, 6'd0,  32'h0, 32'h4, 32'h0, 32'h0, 1'b1, 5'd2, 2'b00, 4'd5}, // R5
    '{12'hC04, 2'd3, 1'b1, 1'b0, 1'b1, 6'd29, ALL, 32'h0, 32'h0, 32'h0, 1'b1, 5'd4, 2'b00, 4'd6}, // R6
    '{12'hC01, 2'd1, 1'b0, 1'b0, 1'b1, 6'd29, ALL, 32'hFFFF_FFFD, ALL, ALL, 1'b1, 5'd1, 2'b01, 4'd7}, // R7
    '{12'hC01, 2'd1, 1'b1, 1'b0, 1'b1, 6'd29, ALL, 32'hFFFF_FFFD, 32'h0, ALL, 1'b1, 5'd1, 2'b01, 4'd7}, // R7
    '{12'hC03, 2'd1, 1'b1, 1'b0, 1'b1, 6'd29, ALL, ALL, 32'hFFFF_FFF7, ALL, 1'b1, 5'd3, 2'b10, 4'd8}, // R8
    '{12'hC03, 2'd0, 1'b1, 1'b0, 1'b1, 6'd29, ALL, ALL, 32'hFFFF_FFF7, 32'h0, 1'b1, 5'd3, 2'b10, 4'd8}, // R8
    '{12'hC07, 2'd0, 1'b0, 1'b0, 1'b1, 6'd29, ALL, ALL, ALL, 32'hFFFF_FF7F, 1'b1, 5'd7, 2'b01, 4'd9}, // R9
    '{12'hC07, 2'd0, 1'b1, 1'b0, 1'b1, 6'd29, ALL, ALL, ALL, 32'hFFFF_FF7F, 1'b1, 5'd7, 2'b10, 4'd9}, // R9
    '{12'hC07, 2'd0, 1'b0, 1'b0, 1'b0, 6'd29, ALL, ALL, ALL, 32'hFFFF_FF7F, 1'b1, 5'd7, 2'b00, 4'd9}, // R9
    '{12'hC07, 2'd1, 1'b0, 1'b0, 1'b1, 6'd29, ALL, ALL, ALL, 32'h0, 1'b1, 5'd7, 2'b00, 4'd10}, // R10
    '{12'hC07, 2'd0, 1'b0, 1'b0, 1'b1, 6'd29, ALL, ALL, 32'h0, ALL, 1'b1, 5'd7, 2'b00, 4'd10}, // R10
    '{12'hC07, 2'd1, 1'b0, 1'b0, 1'b1, 6'd29, ALL, ALL, 32'h0, ALL, 1'b1, 5'd7, 2'b00, 4'd10}, // R10
    '{12'hC9F, 2'd3, 1'b0, 1'b1, 1'b1, 6'd29, ALL, ALL, ALL, ALL, 1'b1, 5'd31, 2'b00, 4'd2}   // R2
  };

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [11:0] csrAddr = '0;
  logic [1:0]  privLvl = '0;
  logic        virtOn = 1'b0;
  logic        isRv32 = 1'b0;
  logic        sModeImpl = 1'b0;
  logic [5:0]  hpmCount = '0;
  logic [31:0] hpmAvail = '0;
  logic [31:0] mEnable = '0;
  logic [31:0] hEnable = '0;
  logic [31:0] sEnable = '0;
  logic        isCounter;
  logic [4:0]  ctrIndex;
  logic [1:0]  verdict;

  int nChecks = 0;
  int nFails = 0;
  int cycles = 0;

  always #5 clk = ~clk;

  ctrAccessGate u_dut (
    .csrAddr   (csrAddr),
    .privLvl   (privLvl),
    .virtOn    (virtOn),
    .isRv32    (isRv32),
    .sModeImpl (sModeImpl),
    .hpmCount  (hpmCount),
    .hpmAvail  (hpmAvail),
    .mEnable   (mEnable),
    .hEnable   (hEnable),
    .sEnable   (sEnable),
    .isCounter (isCounter),
    .ctrIndex  (ctrIndex),
    .verdict   (verdict)
  );

  task automatic finishRun();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > 20000) begin
      nChecks++;
      nFails++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      finishRun();
    end
  end

  task automatic checkOut(string req, logic expCtr, logic [4:0] expIdx, logic [1:0] expV);
    nChecks++;
    if (isCounter !== expCtr || ctrIndex !== expIdx || verdict !== expV) begin
      nFails++;
      $display("FAIL %s addr=%h: actual ctr=%0b idx=%0d v=%b expected ctr=%0b idx=%0d v=%b",
               req, csrAddr, isCounter, ctrIndex, verdict, expCtr, expIdx, expV);
    end
  endtask

  task automatic applyVec(vec_t v);
    @(negedge clk);
    csrAddr = v.addr; privLvl = v.priv; virtOn = v.virt; isRv32 = v.rv32;
    sModeImpl = v.sImpl; hpmCount = v.cnt; hpmAvail = v.avail;
    mEnable = v.m; hEnable = v.h; sEnable = v.s;
    #2;
  endtask

  initial begin
    repeat (3) @(posedge clk);
    rst_n = 1'b1;

    // Reset state: all inputs zero, address 0 is not a counter (R3)
    @(negedge clk); #2;
    checkOut("R3", 1'b0, 5'd0, 2'b00);

    foreach (VECS[i]) begin
      applyVec(VECS[i]);
      checkOut($sformatf("R%0d", VECS[i].req), VECS[i].expCtr, VECS[i].expIdx, VECS[i].expV);
    end

    // R1 and R5 sweep: machine mode across 0xC00..0xC3F with a patterned availability mask
    for (int k = 0; k < 64; k++) begin
      vec_t v;
      logic       eCtr;
      logic [4:0] eIdx;
      logic [1:0] eV;
      v = '{12'hC00 + 12'(k), 2'd3, 1'b0, 1'b0, 1'b1, 6'd29, 32'h5A5A_A5A5,
            ALL, ALL, ALL, 1'b0, 5'd0, 2'b00, 4'd0};
      applyVec(v);
      eCtr = (k < 32);
      eIdx = eCtr ? 5'(k) : 5'd0;
      eV   = (eCtr && k >= 3 && !v.avail[k % 32]) ? 2'b01 : 2'b00;
      checkOut("R1/R5 sweep", eCtr, eIdx, eV);
    end

    // R2 sweep: high half in 64-bit mode is never a counter
    for (int k = 0; k < 32; k++) begin
      vec_t v;
      v = '{12'hC80 + 12'(k), 2'd0, 1'b1, 1'b0, 1'b1, 6'd0, 32'h0,
            32'h0, 32'h0, 32'h0, 1'b0, 5'd0, 2'b00, 4'd2};
      applyVec(v);
      checkOut("R2 wide-mode high half", 1'b0, 5'd0, 2'b00);
    end

    // R7 walking-zero in U mode without supervisor: only the cleared index is refused
    for (int k = 0; k < 32; k++) begin
      vec_t v;
      v = '{12'hC00 + 12'(k), 2'd0, 1'b0, 1'b0, 1'b0, 6'd29, ALL,
            ~(32'h1 << k), 32'h0, 32'h0, 1'b0, 5'd0, 2'b00, 4'd7};
      applyVec(v);
      checkOut("R7 walking zero", 1'b1, 5'(k), 2'b01);
      v.m = ~(32'h1 << ((k + 1) % 32));
      applyVec(v);
      checkOut("R7 neighbour bit", 1'b1, 5'(k), 2'b00);
    end

    // R4: the reserved code never shows across priority combinations
    for (int p = 0; p < 4; p++) begin
      for (int b = 0; b < 8; b++) begin
        vec_t v;
        v = '{12'hC09, 2'(p), b[0], 1'b0, 1'b1, 6'd29, ALL,
              b[1] ? ALL : 32'h0, b[2] ? ALL : 32'h0, 32'h0, 1'b0, 5'd0, 2'b00, 4'd4};
        applyVec(v);
        nChecks++;
        if (verdict === 2'b11) begin
          nFails++;
          $display("FAIL R4 priv=%0d b=%0d: actual v=%b expected not 11", p, b, verdict);
        end
      end
    end

    finishRun();
  end

endmodule